// File: doc/BRIEF.md
# Variable-Page Translation Cache with Context Tags

This block is a small, fully associative cache of address translations placed in front of a page-table walker. Each slot stores one translation: a 4-bit context number, a virtual tag, a physical base, two access-permission bits and two memory-type bits. A slot can map a single 4 KiB page or any larger power-of-two region up to the whole 40-bit space. A 5-bit size code `f` per slot selects a region of 2^(12+f) bytes. Every slot compares the lookup address at its own width, so small and large mappings can sit side by side.

A lookup gives its result in the same cycle. On a hit the upper address bits come from the slot's physical base and the lower bits pass through from the virtual address. On a miss a fill request is raised. The walker answers with a fill, and the fill is written into the first empty slot or, if every slot is full, into the slot a round-robin pointer selects. Software-side invalidation is a flush of one context or a flush of every context.

Top module: `frag_tlb`

## Requirements
- R1: After reset every slot is empty, so any lookup reports a miss and no hit.
- R2: A lookup hits when a valid slot has the same context and covers the address. It returns the translated address and the permission and type bits {rd, wr, sys, snoop} stored by the fill, in the same cycle.
- R3: A slot with size code f matches when VA[39:12+f] equals its tag. The result is the stored base at bits [39:12+f] joined with VA[11+f:0]. When 12+f is 40 or more, the slot covers the whole space and passes the address through unchanged.
- R4: On a fill, the virtual tag and the physical base are both rounded down to the region size, so any offset bits given with the fill are discarded.
- R5: A slot whose context differs from the lookup context never hits.
- R6: `lk_miss_o` is the fill request. It is high exactly when a lookup is presented and does not hit. `lk_hit_o` and `lk_miss_o` are never high together.
- R7: A context flush empties every slot holding that context and leaves slots of other contexts intact.
- R8: A flush-all empties every slot.
- R9: A lookup presented in the same cycle as any flush reports a miss.
- R10: When several slots match one lookup, the slot with the lowest index supplies the result.
- R11: A fill goes to the lowest-numbered empty slot. When no slot is empty it goes to the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on fills made while no slot is empty.
- R12: When a fill and a flush occur in the same cycle, the flush takes effect and the fill is still installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup present |
| lk_ctx_i | input | 4 | Lookup context |
| lk_va_i | input | 40 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup missed; fill request |
| lk_pa_o | output | 40 | Translated address (zero unless hit) |
| lk_rd_o | output | 1 | Read permitted |
| lk_wr_o | output | 1 | Write permitted |
| lk_sys_o | output | 1 | Page in system memory |
| lk_snoop_o | output | 1 | Access must snoop caches |
| fill_valid_i | input | 1 | Install a translation |
| fill_ctx_i | input | 4 | Context of the fill |
| fill_va_i | input | 40 | Virtual address of the fill |
| fill_pa_i | input | 40 | Physical address of the fill |
| fill_frag_i | input | 5 | Region size code f |
| fill_rd_i | input | 1 | Read bit of the fill |
| fill_wr_i | input | 1 | Write bit of the fill |
| fill_sys_i | input | 1 | System bit of the fill |
| fill_snoop_i | input | 1 | Snoop bit of the fill |
| flush_ctx_valid_i | input | 1 | Flush one context |
| flush_ctx_i | input | 4 | Context to flush |
| flush_all_i | input | 1 | Flush every context |

## Verification
The assertions assume that the walker installs only valid translations. They make no assumption that fills avoid overlap with existing slots, since R10 defines what happens when slots overlap. The assertions that a flush empties a slot are written to allow for a fill landing in that slot in the same cycle. The stimulus changes every input on the falling clock edge, so the combinational lookup path is settled when it is sampled. Every overlapping mapping in the stimulus is created on purpose, to test lowest-index priority, and its expected address is worked out from the fill order.

// File: rtl/frag_tlb_pkg.sv
package frag_tlb_pkg;
  localparam int unsigned ADDR_W     = 40;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned FRAG_W     = 5;
  localparam int unsigned CTX_W      = 4;

  typedef struct packed {
    logic rd;
    logic wr;
    logic sys;
    logic snoop;
  } perm_t;

  typedef struct packed {
    logic              valid;
    logic [CTX_W-1:0]  ctx;
    logic [FRAG_W-1:0] frag;
    logic [ADDR_W-1:0] vtag;
    logic [ADDR_W-1:0] pbase;
    perm_t             perm;
  } tlb_entry_t;

  // ones over the in-region offset bits
  function automatic logic [ADDR_W-1:0] frag_mask(input logic [FRAG_W-1:0] f);
    int unsigned sh;
    sh = PAGE_SHIFT + int'(f);
    if (sh >= ADDR_W) return '1;
    return (ADDR_W'(1) << sh) - ADDR_W'(1);
  endfunction
endpackage

// File: rtl/frag_tlb_slot.sv
module frag_tlb_slot
  import frag_tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  tlb_entry_t        wr_entry_i,
  input  logic              flush_all_i,
  input  logic              flush_ctx_valid_i,
  input  logic [CTX_W-1:0]  flush_ctx_i,
  input  logic [CTX_W-1:0]  lk_ctx_i,
  input  logic [ADDR_W-1:0] lk_va_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic [ADDR_W-1:0] pa_o,
  output perm_t             perm_o
);
  tlb_entry_t        ent_q;
  logic              clr;
  logic [ADDR_W-1:0] mask;

  assign clr = flush_all_i || (flush_ctx_valid_i && (ent_q.ctx == flush_ctx_i));

  // fill overrides a same-cycle flush on this slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ent_q <= '0;
    else if (wr_en_i) ent_q <= wr_entry_i;
    else if (clr)     ent_q.valid <= 1'b0;
  end

  assign mask    = frag_mask(ent_q.frag);
  assign valid_o = ent_q.valid;
  assign hit_o   = ent_q.valid && (ent_q.ctx == lk_ctx_i) &&
                   (((lk_va_i ^ ent_q.vtag) & ~mask) == '0);
  assign pa_o    = (ent_q.pbase & ~mask) | (lk_va_i & mask);
  assign perm_o  = ent_q.perm;

  a_r4_tag_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_q.valid |-> (((ent_q.vtag | ent_q.pbase) & mask) == '0));
  a_r7_ctx_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_ctx_valid_i && ent_q.ctx == flush_ctx_i && !wr_en_i) |=> !valid_o);
  a_r8_flush_all_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !wr_en_i) |=> !valid_o);
  a_r12_fill_installs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_o);
endmodule

// File: rtl/frag_tlb_victim.sv
module frag_tlb_victim #(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fill_i,
  input  logic [NUM_ENTRIES-1:0] valid_i,
  output logic [IDX_W-1:0]       victim_o
);
  logic [IDX_W-1:0] rr_q, free_idx;
  logic             have_free;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  assign victim_o = have_free ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (fill_i && !have_free)
      rr_q <= (rr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
  end

  a_r11_prefers_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !(&valid_i)) |-> !valid_i[victim_o]);
  a_r11_pointer_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_i && (&valid_i)) |=> $stable(rr_q));
endmodule

// File: rtl/frag_tlb.sv
module frag_tlb
  import frag_tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [CTX_W-1:0]  lk_ctx_i,
  input  logic [ADDR_W-1:0] lk_va_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic [ADDR_W-1:0] lk_pa_o,
  output logic              lk_rd_o,
  output logic              lk_wr_o,
  output logic              lk_sys_o,
  output logic              lk_snoop_o,
  input  logic              fill_valid_i,
  input  logic [CTX_W-1:0]  fill_ctx_i,
  input  logic [ADDR_W-1:0] fill_va_i,
  input  logic [ADDR_W-1:0] fill_pa_i,
  input  logic [FRAG_W-1:0] fill_frag_i,
  input  logic              fill_rd_i,
  input  logic              fill_wr_i,
  input  logic              fill_sys_i,
  input  logic              fill_snoop_i,
  input  logic              flush_ctx_valid_i,
  input  logic [CTX_W-1:0]  flush_ctx_i,
  input  logic              flush_all_i
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0] slot_valid, slot_hit, grant;
  logic [ADDR_W-1:0]      slot_pa   [NUM_ENTRIES];
  perm_t                  slot_perm [NUM_ENTRIES];
  logic [IDX_W-1:0]       victim_idx;
  logic [ADDR_W-1:0]      fill_mask, sel_pa;
  perm_t                  sel_perm;
  tlb_entry_t             fill_entry;
  logic                   flush_any, any_hit;

  assign flush_any = flush_all_i || flush_ctx_valid_i;
  assign fill_mask = frag_mask(fill_frag_i);

  always_comb begin
    fill_entry.valid      = 1'b1;
    fill_entry.ctx        = fill_ctx_i;
    fill_entry.frag       = fill_frag_i;
    fill_entry.vtag       = fill_va_i & ~fill_mask;
    fill_entry.pbase      = fill_pa_i & ~fill_mask;
    fill_entry.perm.rd    = fill_rd_i;
    fill_entry.perm.wr    = fill_wr_i;
    fill_entry.perm.sys   = fill_sys_i;
    fill_entry.perm.snoop = fill_snoop_i;
  end

  frag_tlb_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fill_i   (fill_valid_i),
    .valid_i  (slot_valid),
    .victim_o (victim_idx)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    frag_tlb_slot u_slot (
      .clk_i             (clk_i),
      .rst_ni            (rst_ni),
      .wr_en_i           (fill_valid_i && (victim_idx == IDX_W'(g))),
      .wr_entry_i        (fill_entry),
      .flush_all_i       (flush_all_i),
      .flush_ctx_valid_i (flush_ctx_valid_i),
      .flush_ctx_i       (flush_ctx_i),
      .lk_ctx_i          (lk_ctx_i),
      .lk_va_i           (lk_va_i),
      .valid_o           (slot_valid[g]),
      .hit_o             (slot_hit[g]),
      .pa_o              (slot_pa[g]),
      .perm_o            (slot_perm[g])
    );
  end

  // lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (slot_hit[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    sel_pa   = '0;
    sel_perm = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (grant[i]) begin
        sel_pa   = sel_pa | slot_pa[i];
        sel_perm = sel_perm | slot_perm[i];
      end
    end
  end

  assign any_hit    = |slot_hit;
  assign lk_hit_o   = lk_valid_i && any_hit && !flush_any;
  assign lk_miss_o  = lk_valid_i && !lk_hit_o;
  assign lk_pa_o    = lk_hit_o ? sel_pa : '0;
  assign lk_rd_o    = lk_hit_o && sel_perm.rd;
  assign lk_wr_o    = lk_hit_o && sel_perm.wr;
  assign lk_sys_o   = lk_hit_o && sel_perm.sys;
  assign lk_snoop_o = lk_hit_o && sel_perm.snoop;

  a_r6_hit_miss_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_miss_o));
  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(lk_hit_o || lk_miss_o));
  a_r9_flush_forces_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && flush_any) |-> lk_miss_o);
  a_r10_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant == '0) == (slot_hit == '0)));
  a_r2_hit_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> ((slot_hit & slot_valid) != '0));
endmodule

// File: tb/frag_tlb_bench.sv
module frag_tlb_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [3:0]  lk_ctx_i = '0;
  logic [39:0] lk_va_i = '0;
  logic        lk_hit_o, lk_miss_o, lk_rd_o, lk_wr_o, lk_sys_o, lk_snoop_o;
  logic [39:0] lk_pa_o;
  logic        fill_valid_i = 1'b0;
  logic [3:0]  fill_ctx_i = '0;
  logic [39:0] fill_va_i = '0, fill_pa_i = '0;
  logic [4:0]  fill_frag_i = '0;
  logic        fill_rd_i = 1'b0, fill_wr_i = 1'b0, fill_sys_i = 1'b0, fill_snoop_i = 1'b0;
  logic        flush_ctx_valid_i = 1'b0;
  logic [3:0]  flush_ctx_i = '0;
  logic        flush_all_i = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  frag_tlb u_frag_tlb (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [3:0] ctx, input logic [39:0] va, input logic [39:0] pa,
                      input logic [4:0] f, input logic [3:0] perm);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_ctx_i = ctx; fill_va_i = va; fill_pa_i = pa; fill_frag_i = f;
    {fill_rd_i, fill_wr_i, fill_sys_i, fill_snoop_i} = perm;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic flush_all();
    @(negedge clk_i); flush_all_i = 1'b1;
    @(negedge clk_i); flush_all_i = 1'b0;
  endtask

  task automatic flush_ctx(input logic [3:0] ctx);
    @(negedge clk_i); flush_ctx_valid_i = 1'b1; flush_ctx_i = ctx;
    @(negedge clk_i); flush_ctx_valid_i = 1'b0;
  endtask

  task automatic look(input logic [3:0] ctx, input logic [39:0] va);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_ctx_i = ctx; lk_va_i = va;
    #2;
  endtask

  task automatic expect_hit(input string req, input logic [3:0] ctx, input logic [39:0] va,
                            input logic [39:0] pa);
    look(ctx, va);
    chk(req, {62'd0, lk_hit_o, lk_miss_o}, 64'd2);
    chk(req, {24'd0, lk_pa_o}, {24'd0, pa});
    lk_valid_i = 1'b0;
  endtask

  task automatic expect_miss(input string req, input logic [3:0] ctx, input logic [39:0] va);
    look(ctx, va);
    chk(req, {62'd0, lk_hit_o, lk_miss_o}, 64'd1);
    lk_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    expect_miss("R1", 4'd0, 40'h0);
    expect_miss("R1", 4'd15, 40'hFF_FFFF_F000);
    @(negedge clk_i); #2;
    chk("R6 idle", {62'd0, lk_hit_o, lk_miss_o}, 64'd0);
  endtask

  task automatic t_replace();
    for (int i = 0; i < 8; i++) fill(4'd0, 40'(i) << 12, (40'h100 + 40'(i)) << 12, 5'd0, 4'b1000);
    for (int i = 0; i < 8; i++) expect_hit("R11 full", 4'd0, 40'(i) << 12, (40'h100 + 40'(i)) << 12);
    fill(4'd0, 40'h8000, 40'h999000, 5'd0, 4'b1000);   // evicts slot 0
    expect_miss("R11 rr0", 4'd0, 40'h0);
    expect_hit("R11 rr0", 4'd0, 40'h1000, 40'h101000);
    expect_hit("R11 new", 4'd0, 40'h8000, 40'h999000);
    fill(4'd0, 40'h9000, 40'h777000, 5'd0, 4'b1000);   // evicts slot 1
    expect_miss("R11 rr1", 4'd0, 40'h1000);
    expect_hit("R11 rr1", 4'd0, 40'h2000, 40'h102000);
    flush_all();
  endtask

  task automatic t_basic();
    fill(4'd3, 40'h12_3456_7000, 40'h00_ABCD_E000, 5'd0, 4'b1010);
    look(4'd3, 40'h12_3456_7ABC);
    chk("R2 hit", {63'd0, lk_hit_o}, 64'd1);
    chk("R2 pa", {24'd0, lk_pa_o}, 64'h00_ABCD_EABC);
    chk("R2 perm", {60'd0, lk_rd_o, lk_wr_o, lk_sys_o, lk_snoop_o}, 64'hA);
    lk_valid_i = 1'b0;
    expect_miss("R6 miss", 4'd3, 40'h12_3456_8000);
    flush_all();
  endtask

  task automatic t_frag();
    fill(4'd1, 40'h40_0012_3456, 40'h05_0009_8765, 5'd8, 4'b0101);
    expect_hit("R3 top", 4'd1, 40'h40_001F_FFFF, 40'h05_000F_FFFF);
    expect_hit("R4 base", 4'd1, 40'h40_0010_0000, 40'h05_0000_0000);
    expect_miss("R3 above", 4'd1, 40'h40_0020_0000);
    expect_miss("R3 below", 4'd1, 40'h40_000F_FFFF);
    fill(4'd2, 40'h12_3456_7890, 40'h7F_0000_1234, 5'd31, 4'b1100);
    expect_hit("R3 whole", 4'd2, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF);
    expect_hit("R3 whole", 4'd2, 40'h00_0000_0000, 40'h00_0000_0000);
    flush_all();
  endtask

  task automatic t_ctx();
    fill(4'd5, 40'h1000, 40'h2000, 5'd0, 4'b1000);
    expect_miss("R5", 4'd6, 40'h1000);
    expect_hit("R5", 4'd5, 40'h1000, 40'h2000);
    flush_all();
  endtask

  task automatic t_flush_ctx();
    fill(4'd7, 40'hA000, 40'h1A000, 5'd0, 4'b1000);
    fill(4'd8, 40'hB000, 40'h1B000, 5'd0, 4'b1000);
    fill(4'd7, 40'hC000, 40'h1C000, 5'd0, 4'b1000);
    flush_ctx(4'd7);
    expect_miss("R7", 4'd7, 40'hA000);
    expect_miss("R7", 4'd7, 40'hC000);
    expect_hit("R7 keep", 4'd8, 40'hB000, 40'h1B000);
  endtask

  task automatic t_flush_all();
    fill(4'd9, 40'hD000, 40'h1D000, 5'd0, 4'b1000);
    flush_all();
    expect_miss("R8", 4'd8, 40'hB000);
    expect_miss("R8", 4'd9, 40'hD000);
  endtask

  task automatic t_flush_same();
    fill(4'd1, 40'hE000, 40'h3E000, 5'd0, 4'b1000);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_ctx_i = 4'd1; lk_va_i = 40'hE000;
    flush_ctx_valid_i = 1'b1; flush_ctx_i = 4'd9;
    #2;
    chk("R9", {62'd0, lk_hit_o, lk_miss_o}, 64'd1);
    @(negedge clk_i);
    flush_ctx_valid_i = 1'b0; lk_valid_i = 1'b0;
    expect_hit("R9 after", 4'd1, 40'hE000, 40'h3E000);
    flush_all();
  endtask

  task automatic t_prio();
    fill(4'd0, 40'h0, 40'h10_0000_0000, 5'd4, 4'b1000);
    fill(4'd0, 40'h3000, 40'h20_0000_0000, 5'd0, 4'b1000);
    expect_hit("R10 big first", 4'd0, 40'h3010, 40'h10_0000_3010);
    flush_all();
    fill(4'd0, 40'h3000, 40'h20_0000_0000, 5'd0, 4'b1000);
    fill(4'd0, 40'h0, 40'h10_0000_0000, 5'd4, 4'b1000);
    expect_hit("R10 small first", 4'd0, 40'h3010, 40'h20_0000_0010);
    flush_all();
  endtask

  task automatic t_fill_flush();
    fill(4'd4, 40'h5_0000, 40'h6_0000, 5'd0, 4'b1000);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_ctx_i = 4'd4; fill_va_i = 40'h7_0000; fill_pa_i = 40'h8_0000;
    fill_frag_i = 5'd0; {fill_rd_i, fill_wr_i, fill_sys_i, fill_snoop_i} = 4'b1000;
    flush_all_i = 1'b1;
    @(negedge clk_i);
    fill_valid_i = 1'b0; flush_all_i = 1'b0;
    expect_miss("R12 flushed", 4'd4, 40'h5_0000);
    expect_hit("R12 installed", 4'd4, 40'h7_0000, 40'h8_0000);
    flush_all();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_replace();
    t_basic();
    t_frag();
    t_ctx();
    t_flush_ctx();
    t_flush_all();
    t_flush_same();
    t_prio();
    t_fill_flush();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule